// File: doc/BRIEF.md
# Dual Reference Clock Selector with Hitless Switchover

This block decides which of two reference clocks drives a PLL input. The choice is made in one of three ways. A configuration bit can name the reference. An external select pin can choose it. In automatic mode, the per-reference "frequency good" flags choose it: the block leaves a reference whose flag drops, provided the other reference is healthy. When automatic mode is on, it forces both reference input buffers to power up. In differential input mode, automatic selection is disabled and the first reference path is always used.

Changing the reference does not simply flip the mux. By default a hitless sequence is used. The forwarded clock is first held low. The select then moves only while the outgoing clock is low. The output is released once the incoming clock has shown two rising edges. A configuration bit bypasses this sequence so that the select follows the request at once.

A five-bit monitor code routes one of several clocks or status flags to a single diagnostic output. The top code bit inverts that output. All asynchronous inputs are sampled into the system clock through two-flop synchronizers. Everything runs on one clock with a synchronous reset.

Top module: `refclk_switch`

## Requirements
- R1: While reset is high and on the first cycle after it, `ref_sel` is 0, `swo_pulse` is 0, and each power enable follows its configuration bit. With `cfg` all zero, every configuration feature is off, both powers are off, and the forwarded clock follows reference 1.
- R2: Manual mode applies when cfg[0] (auto) is 0 or cfg[4] (differential) is 1. In manual mode with cfg[2] (use pin) = 0, the target reference is cfg[3], where 0 means reference 1 and 1 means reference 2.
- R3: In manual mode with cfg[2] = 1, the target is `sel_pin` after two synchronizer stages. With deglitch off, `ref_sel` changes at the third rising clock edge after the pin changes.
- R4: In automatic mode (cfg[0] = 1, cfg[4] = 0), both power enables are 1 whatever cfg[5] and cfg[6] hold. The block switches away from the active reference when its synchronized good flag is 0 and the other reference's flag is 1. When both flags are 0, the selection is kept.
- R5: In automatic mode, with reference 2 active and reference 1 good, the block returns to reference 1 when cfg[1] (stay) is 0. When cfg[1] is 1 and reference 2 is good, it remains on reference 2.
- R6: With cfg[4] = 1, the target is always reference 1, and the automatic bit has no effect on selection or power.
- R7: With cfg[7] = 0, a target change first drives `ref_out` low on the next cycle. `ref_sel` then flips on a cycle where the synchronized outgoing clock is low. `ref_out` stays low until the second synchronized rising edge of the incoming clock. If the target returns to the current selection before the flip, the change is abandoned.
- R8: With cfg[7] = 1, `ref_sel` takes the target at the next clock edge and `ref_out` is never held low.
- R9: `swo_pulse` is high for exactly the one cycle in which `ref_sel` holds a new value.
- R10: `mon_out` is the source chosen by mon_sel[3:0], XORed with mon_sel[4]. The codes are: 0 ground, 1 ref 1 clock, 2 ref 2 clock, 3 selected clock, 4 unselected clock, 5 selected good, 6 unselected good, 7 ref 1 good, 8 ref 2 good, 9 both good, 10 lock AND selected good AND clock good, 11 clock good, 12 selection indicator, 13 lock, 14 holdover. Code 15 gives 0 in both polarities. In differential mode, the unselected clock and the unselected good flag read as 0 before inversion.
- R11: Code 12 reads 0 for reference 1 and 1 for reference 2 when mon_sel[4] = 0, and the reverse when mon_sel[4] = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg | input | 8 | Configuration byte; bits 0 auto, 1 stay, 2 use pin, 3 manual select, 4 differential, 5 ref 1 power, 6 ref 2 power, 7 deglitch off |
| mon_sel | input | 5 | Monitor source code, bit 4 inverts |
| sel_pin | input | 1 | External reference select, asynchronous |
| ref1_clk | input | 1 | Reference 1 clock, sampled |
| ref2_clk | input | 1 | Reference 2 clock, sampled |
| ref1_good | input | 1 | Reference 1 frequency good |
| ref2_good | input | 1 | Reference 2 frequency good |
| clk_good | input | 1 | Feedback clock frequency good |
| dlock | input | 1 | Digital lock detect |
| holdover | input | 1 | Holdover active |
| ref_out | output | 1 | Forwarded selected reference, gated during switchover |
| ref_sel | output | 1 | Registered selection, 0 = ref 1 |
| swo_pulse | output | 1 | One-cycle pulse on each selection change |
| pwr1_en | output | 1 | Reference 1 input power enable |
| pwr2_en | output | 1 | Reference 2 input power enable |
| mon_out | output | 1 | Monitor output |

## Verification
Several properties are checked on every cycle. A selection change always carries a pulse, and the pulse never appears without a change. The forwarded clock is low on any hitless flip. Differential mode never leaves reference 1. Automatic mode keeps both powers on, holds when both flags are bad, and honours the sticky flag. A register-chosen reference is taken in one edge when deglitch is off. Only the bench scenarios can show the full switchover timeline: waiting for the outgoing low and counting incoming edges. They also cover the revert-to-reference-1 path, pin latency through the synchronizers, and every monitor code in both polarities, all compared against the reference model.

// File: rtl/refclk_switch.sv
module refclk_switch #(
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_EDGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cfg,
  input  logic [4:0] mon_sel,
  input  logic       sel_pin,
  input  logic       ref1_clk,
  input  logic       ref2_clk,
  input  logic       ref1_good,
  input  logic       ref2_good,
  input  logic       clk_good,
  input  logic       dlock,
  input  logic       holdover,
  output logic       ref_out,
  output logic       ref_sel,
  output logic       swo_pulse,
  output logic       pwr1_en,
  output logic       pwr2_en,
  output logic       mon_out
);
  localparam int CW = $clog2(SETTLE_EDGES + 1);
  localparam int B_AUTO = 0, B_STAY = 1, B_PIN = 2, B_MSEL = 3;
  localparam int B_DIFF = 4, B_PWR1 = 5, B_PWR2 = 6, B_DGOFF = 7;

  typedef enum logic [1:0] {RUN, DRAIN, SETTLE} st_t;

  logic [7:0] sy [SYNC_STAGES];
  logic [7:0] s;
  logic r1s, r2s, pins, g1s, g2s, cks, dls, hos;
  logic r1p, r2p;
  logic auto_on, want, old_clk, new_rise;
  logic sel_good, unsel_good, sel_clk, unsel_clk, src;
  logic gate;
  logic [CW-1:0] edges;
  st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= '0;
      r1p <= 1'b0;
      r2p <= 1'b0;
    end else begin
      sy[0] <= {holdover, dlock, clk_good, ref2_good, ref1_good, sel_pin, ref2_clk, ref1_clk};
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
      r1p <= r1s;
      r2p <= r2s;
    end
  end

  assign s = sy[SYNC_STAGES-1];
  assign {hos, dls, cks, g2s, g1s, pins, r2s, r1s} = s;

  assign auto_on = cfg[B_AUTO] & ~cfg[B_DIFF];
  assign pwr1_en = cfg[B_PWR1] | auto_on;
  assign pwr2_en = cfg[B_PWR2] | auto_on;

  always_comb begin
    if (cfg[B_DIFF])
      want = 1'b0;
    else if (auto_on)
      want = ref_sel ? ~(g1s & (~cfg[B_STAY] | ~g2s)) : (~g1s & g2s);
    else
      want = cfg[B_PIN] ? pins : cfg[B_MSEL];
  end

  assign old_clk  = ref_sel ? r2s : r1s;
  assign new_rise = ref_sel ? (r2s & ~r2p) : (r1s & ~r1p);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RUN;
      gate      <= 1'b1;
      edges     <= '0;
      ref_sel   <= 1'b0;
      swo_pulse <= 1'b0;
    end else begin
      swo_pulse <= 1'b0;
      if (cfg[B_DGOFF]) begin
        st    <= RUN;
        gate  <= 1'b1;
        edges <= '0;
        if (want != ref_sel) begin
          ref_sel   <= want;
          swo_pulse <= 1'b1;
        end
      end else begin
        case (st)
          RUN: if (want != ref_sel) begin
            gate <= 1'b0;
            st   <= DRAIN;
          end
          DRAIN: if (want == ref_sel) begin
            gate <= 1'b1;
            st   <= RUN;
          end else if (!old_clk) begin
            ref_sel   <= ~ref_sel;
            swo_pulse <= 1'b1;
            edges     <= '0;
            st        <= SETTLE;
          end
          SETTLE: if (new_rise) begin
            if (edges == CW'(SETTLE_EDGES - 1)) begin
              gate  <= 1'b1;
              edges <= '0;
              st    <= RUN;
            end else begin
              edges <= edges + CW'(1);
            end
          end
          default: st <= RUN;
        endcase
      end
    end
  end

  assign ref_out = gate & old_clk;

  assign sel_clk    = old_clk;
  assign unsel_clk  = ~cfg[B_DIFF] & (ref_sel ? r1s : r2s);
  assign sel_good   = ref_sel ? g2s : g1s;
  assign unsel_good = ~cfg[B_DIFF] & (ref_sel ? g1s : g2s);

  always_comb begin
    case (mon_sel[3:0])
      4'd1:    src = r1s;
      4'd2:    src = r2s;
      4'd3:    src = sel_clk;
      4'd4:    src = unsel_clk;
      4'd5:    src = sel_good;
      4'd6:    src = unsel_good;
      4'd7:    src = g1s;
      4'd8:    src = g2s;
      4'd9:    src = g1s & g2s;
      4'd10:   src = dls & sel_good & cks;
      4'd11:   src = cks;
      4'd12:   src = ref_sel;
      4'd13:   src = dls;
      4'd14:   src = hos;
      default: src = 1'b0;
    endcase
  end

  assign mon_out = (mon_sel[3:0] == 4'hF) ? 1'b0 : (src ^ mon_sel[4]);
endmodule

// File: rtl/refclk_switch_chk.sv
module refclk_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg,
  input logic       ref_out,
  input logic       ref_sel,
  input logic       swo_pulse,
  input logic       pwr1_en,
  input logic       pwr2_en,
  input logic       g1s,
  input logic       g2s
);
  logic auto_q;
  assign auto_q = cfg[0] & ~cfg[4];

  AST_AUTO_POWER: assert property (@(posedge clk) disable iff (rst) auto_q |-> (pwr1_en && pwr2_en)); // R4
  AST_AUTO_BOTH_BAD_HOLD: assert property (@(posedge clk) disable iff (rst) $past(auto_q && !g1s && !g2s) |-> $stable(ref_sel)); // R4
  AST_STAY_ON_SECOND: assert property (@(posedge clk) disable iff (rst) $past(auto_q && cfg[1] && ref_sel && g2s) |-> ref_sel); // R5
  AST_DIFF_KEEPS_FIRST: assert property (@(posedge clk) disable iff (rst) $past(cfg[4] && !ref_sel) |-> !ref_sel); // R6
  AST_HITLESS_LOW: assert property (@(posedge clk) disable iff (rst) (!$stable(ref_sel) && $past(!cfg[7])) |-> !ref_out); // R7
  AST_DIRECT_REG_SELECT: assert property (@(posedge clk) disable iff (rst) $past(cfg[7] && !cfg[2] && (!cfg[0] || cfg[4])) |-> (ref_sel == $past(cfg[3] && !cfg[4]))); // R2
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst) !$stable(ref_sel) |-> swo_pulse); // R9
  AST_PULSE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst) swo_pulse |-> !$stable(ref_sel)); // R9
endmodule

bind refclk_switch refclk_switch_chk u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .ref_out(ref_out), .ref_sel(ref_sel),
  .swo_pulse(swo_pulse), .pwr1_en(pwr1_en), .pwr2_en(pwr2_en), .g1s(g1s), .g2s(g2s)
);

// File: tb/refclk_switch_bench.sv
`timescale 1ns/1ps
module refclk_switch_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg = '0;
  logic [4:0] mon_sel = '0;
  logic sel_pin = 0, ref1_clk = 0, ref2_clk = 0;
  logic ref1_good = 0, ref2_good = 0, clk_good = 0, dlock = 0, holdover = 0;
  logic ref_out, ref_sel, swo_pulse, pwr1_en, pwr2_en, mon_out;

  int nvec = 0, nfail = 0, cyc = 0, pulses = 0;
  bit done = 0;

  refclk_switch u_refclk_switch (
    .clk(clk), .rst(rst), .cfg(cfg), .mon_sel(mon_sel), .sel_pin(sel_pin),
    .ref1_clk(ref1_clk), .ref2_clk(ref2_clk), .ref1_good(ref1_good), .ref2_good(ref2_good),
    .clk_good(clk_good), .dlock(dlock), .holdover(holdover),
    .ref_out(ref_out), .ref_sel(ref_sel), .swo_pulse(swo_pulse),
    .pwr1_en(pwr1_en), .pwr2_en(pwr2_en), .mon_out(mon_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int r1cnt = 0, r2cnt = 0;
  always @(negedge clk) begin
    r1cnt = (r1cnt + 1) % 3; if (r1cnt == 0) ref1_clk = ~ref1_clk;
    r2cnt = (r2cnt + 1) % 5; if (r2cnt == 0) ref2_clk = ~ref2_clk;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: two sync stages, switchover phase 0 idle / 1 wait-low / 2 counting
  bit [7:0] q1 = 0, q2 = 0;
  bit pp1 = 0, pp2 = 0, msel = 0, mgate = 1, mpulse = 0;
  int mphase = 0, mcount = 0;

  function automatic bit target();
    if (cfg[4]) return 0;
    if (cfg[0]) begin
      if (!msel) return (!q2[3] && q2[4]);
      if (q2[3] && (!cfg[1] || !q2[4])) return 0;
      return 1;
    end
    return cfg[2] ? q2[2] : cfg[3];
  endfunction

  function automatic bit mon_model();
    bit [15:0] v;
    bit sg;
    sg = msel ? q2[4] : q2[3];
    v = '0;
    v[1] = q2[0]; v[2] = q2[1];
    v[3] = msel ? q2[1] : q2[0];
    v[4] = cfg[4] ? 1'b0 : (msel ? q2[0] : q2[1]);
    v[5] = sg;
    v[6] = cfg[4] ? 1'b0 : (msel ? q2[3] : q2[4]);
    v[7] = q2[3]; v[8] = q2[4]; v[9] = q2[3] & q2[4];
    v[10] = q2[6] & sg & q2[5]; v[11] = q2[5]; v[12] = msel;
    v[13] = q2[6]; v[14] = q2[7];
    if (mon_sel[3:0] == 4'hF) return 0;
    return v[mon_sel[3:0]] ^ mon_sel[4];
  endfunction

  always @(posedge clk) begin
    bit w, rise, outgoing;
    if (rst) begin
      q1 = 0; q2 = 0; pp1 = 0; pp2 = 0; msel = 0; mgate = 1; mpulse = 0; mphase = 0; mcount = 0;
    end else begin
      w = target();
      mpulse = 0;
      outgoing = msel ? q2[1] : q2[0];
      rise = msel ? (q2[1] && !pp2) : (q2[0] && !pp1);
      if (cfg[7]) begin
        mphase = 0; mgate = 1; mcount = 0;
        if (w != msel) begin msel = w; mpulse = 1; end
      end else if (mphase == 0) begin
        if (w != msel) begin mgate = 0; mphase = 1; end
      end else if (mphase == 1) begin
        if (w == msel) begin mgate = 1; mphase = 0; end
        else if (!outgoing) begin msel = !msel; mpulse = 1; mphase = 2; mcount = 0; end
      end else if (rise) begin
        mcount++;
        if (mcount == 2) begin mgate = 1; mphase = 0; mcount = 0; end
      end
      pp1 = q2[0]; pp2 = q2[1];
      q2 = q1;
      q1 = {holdover, dlock, clk_good, ref2_good, ref1_good, sel_pin, ref2_clk, ref1_clk};
    end
    #1;
    if (!done) begin
      nvec++;
      if (ref_sel !== msel) begin nfail++; $display("FAIL R2/R4/R7: ref_sel actual=%0d expected=%0d", ref_sel, msel); end
      if (swo_pulse !== mpulse) begin nfail++; $display("FAIL R9: swo_pulse actual=%0d expected=%0d", swo_pulse, mpulse); end
      if (ref_out !== (mgate & (msel ? q2[1] : q2[0]))) begin nfail++; $display("FAIL R7: ref_out actual=%0d expected=%0d", ref_out, mgate & (msel ? q2[1] : q2[0])); end
      if (pwr1_en !== (cfg[5] | (cfg[0] & ~cfg[4]))) begin nfail++; $display("FAIL R4: pwr1_en actual=%0d expected=%0d", pwr1_en, cfg[5] | (cfg[0] & ~cfg[4])); end
      if (pwr2_en !== (cfg[6] | (cfg[0] & ~cfg[4]))) begin nfail++; $display("FAIL R4: pwr2_en actual=%0d expected=%0d", pwr2_en, cfg[6] | (cfg[0] & ~cfg[4])); end
      if (mon_out !== mon_model()) begin nfail++; $display("FAIL R10: mon_out code=%0d actual=%0d expected=%0d", mon_sel, mon_out, mon_model()); end
      if (swo_pulse === 1'b1) pulses++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog: cycles actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    check("R1", "ref_sel in reset", ref_sel, 0);
    check("R1", "swo_pulse in reset", swo_pulse, 0);
    rst = 0;
    tick(1);
    check("R1", "ref_sel after reset", ref_sel, 0);
    check("R1", "pwr1_en default", pwr1_en, 0);
    check("R1", "pwr2_en default", pwr2_en, 0);
    ref1_good = 1; ref2_good = 1; clk_good = 1; dlock = 1;
    tick(4);

    // R2 and R7: register select with hitless sequence
    pulses = 0;
    cfg = 8'b0000_1000;
    tick(60);
    check("R2", "manual register picks ref 2", ref_sel, 1);
    check("R9", "one pulse per change", pulses, 1);
    cfg = 8'b0000_0000;
    tick(60);
    check("R7", "hitless return to ref 1", ref_sel, 0);

    // R8: deglitch bypass
    cfg = 8'b1000_1000;
    tick(1);
    check("R8", "immediate select with deglitch off", ref_sel, 1);
    cfg = 8'b1000_0000;
    tick(1);
    check("R8", "immediate return", ref_sel, 0);

    // R3: pin select latency
    sel_pin = 1; cfg = 8'b1000_0100;
    tick(2);
    check("R3", "pin not yet through synchronizers", ref_sel, 0);
    tick(1);
    check("R3", "pin select after third edge", ref_sel, 1);
    sel_pin = 0;
    tick(4);
    check("R3", "pin back to ref 1", ref_sel, 0);

    // R4/R5: automatic mode
    cfg = 8'b0000_0001;
    tick(2);
    check("R4", "auto forces pwr1", pwr1_en, 1);
    check("R4", "auto forces pwr2", pwr2_en, 1);
    ref1_good = 0;
    tick(60);
    check("R4", "auto leaves bad ref 1", ref_sel, 1);
    ref2_good = 0;
    tick(60);
    check("R4", "both bad holds", ref_sel, 1);
    ref1_good = 1; ref2_good = 1;
    tick(60);
    check("R5", "auto reverts to ref 1", ref_sel, 0);
    cfg = 8'b0000_0011;
    ref1_good = 0;
    tick(60);
    check("R5", "sticky mode moves to ref 2", ref_sel, 1);
    ref1_good = 1;
    tick(60);
    check("R5", "sticky mode stays on ref 2", ref_sel, 1);
    ref2_good = 0;
    tick(60);
    check("R4", "sticky mode leaves bad ref 2", ref_sel, 0);
    ref2_good = 1;

    // R6: differential overrides auto
    cfg = 8'b0000_1000;
    tick(60);
    cfg = 8'b0001_0001;
    ref1_good = 0;
    tick(60);
    check("R6", "differential forces ref 1", ref_sel, 0);
    check("R6", "differential cancels auto power", pwr1_en, 0);
    ref1_good = 1;

    // R10/R11: monitor sweep
    cfg = 8'b1000_1000;
    holdover = 1;
    tick(4);
    for (int c = 0; c < 32; c++) begin
      mon_sel = c[4:0];
      tick(3);
    end
    mon_sel = 5'd12; tick(1);
    check("R11", "indicator true polarity on ref 2", mon_out, 1);
    mon_sel = 5'd28; tick(1);
    check("R11", "indicator inverted on ref 2", mon_out, 0);
    mon_sel = 5'd15; tick(1);
    check("R10", "unused code true", mon_out, 0);
    mon_sel = 5'd31; tick(1);
    check("R10", "unused code inverted", mon_out, 0);
    mon_sel = 5'd16; tick(1);
    check("R10", "ground inverted reads high", mon_out, 1);

    // mixed stimulus against the model
    for (int k = 0; k < 4000; k++) begin
      if (k % 37 == 0) cfg = 8'($urandom);
      if (k % 23 == 0) {holdover, dlock, clk_good, ref2_good, ref1_good} = 5'($urandom);
      if (k % 11 == 0) sel_pin = 1'($urandom);
      mon_sel = 5'($urandom);
      tick(1);
    end
    tick(2);
    finish_run();
  end
endmodule